// File: doc/BRIEF.md
# Per-Channel Latched Interrupt Status Bank

This block holds the interrupt state for a set of DMA channels. Each channel's engine presents two event inputs: transfer finished and abort accepted. Each event appears as a live bit in a read-only status view. Each event is also captured in a sticky request register. Software clears a request bit by writing a one to that bit position. A per-channel enable mask selects which captured events can raise an interrupt. A read-only detect view shows the request bits that are also enabled.

Each channel drives its own level interrupt, which is high while its detect view is non-zero. The bank also ORs all channel interrupts onto one shared line. A handler on the shared line reads each channel's detect view to find the source. A channel that reads zero there is not the one asserting the line. Abort events are captured even while masked, so software can poll the request register to wait for an abort to finish.

Registers are reached through a simple write strobe, a channel index and a byte offset inside the channel window. Read data is returned in the same cycle, combinationally.

Top module: `chan_irq_bank`

## Requirements
- R1: While the synchronous active-low reset is low on a clock edge, every channel's request and enable registers become zero, and all interrupt outputs are low on the following cycle.
- R2: Reading offset 0x10 returns the live event inputs of the addressed channel in the same cycle: bit 1 is the done input and bit 13 is the abort input; all other bits read zero.
- R3: An event input that is high on a clock edge sets its bit in that channel's request register (bit 1 done, bit 13 abort) from the next cycle, whatever the enable mask holds.
- R4: A write to offset 0x14 clears each request bit written as one and leaves every bit written as zero unchanged; the register reads back at 0x14.
- R5: When an event and a write-one-to-clear of the same request bit fall on the same edge, the bit stays set.
- R6: A write to offset 0x18 loads the enable mask. Only bits 1 and 13 are stored; all other bits read back as zero.
- R7: Offset 0x1C reads the request register ANDed with the enable mask. Writes to 0x10 and 0x1C change nothing, and any offset other than 0x10, 0x14, 0x18 and 0x1C reads zero.
- R8: Each channel interrupt is high exactly when that channel's detect value is non-zero. The shared interrupt is the OR of all channel interrupts.
- R9: A register write changes only the channel selected by the channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_done | input | NCH | Per-channel transfer-finished event |
| evt_abort | input | NCH | Per-channel abort-accepted event |
| bus_wr | input | 1 | Register write strobe |
| bus_chan | input | CHW | Channel index for read and write |
| bus_off | input | OFFW | Byte offset inside the channel window |
| bus_wdata | input | DW | Write data |
| rd_data | output | DW | Read data for the addressed register |
| irq_chan | output | NCH | Level interrupt per channel |
| irq_shared | output | 1 | OR of all channel interrupts |

## Verification
On every cycle, the assertions check several relations. An event sets its request bit on the next cycle, even when a clear of that bit falls on the same edge. A one written to a request bit clears it when no new event competes. Unstored enable bits stay zero. A channel with nothing enabled and pending keeps its interrupt low, and the shared line follows the channel lines. Channels that receive neither an event nor a write hold their request state. Some behaviours can only be shown by the bench's scenarios. These include the read-back values at each offset, the masked abort that latches without an interrupt, and the cleared state after reset. Writes to the read-only offsets also fall here, along with long random mixes of events and writes across channels, compared against a cycle model.

// File: rtl/irq_stat_pkg.sv
// Shared constants and types for the per-channel interrupt status bank.
// Assumes a register width of at least 14 bits so both event bits fit.
package irq_stat_pkg;
    localparam int DONE_BIT  = 1;
    localparam int ABORT_BIT = 13;

    localparam logic [7:0] OFF_RAW = 8'h10;
    localparam logic [7:0] OFF_REQ = 8'h14;
    localparam logic [7:0] OFF_EN  = 8'h18;
    localparam logic [7:0] OFF_DET = 8'h1C;

    typedef enum logic [1:0] {
        SEL_RAW = 2'd0,
        SEL_REQ = 2'd1,
        SEL_EN  = 2'd2,
        SEL_DET = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
// Decodes a byte offset inside a channel window into a register select.
// Assumes offsets wider than 8 bits are zero-extended versions of the map.
module irq_addr_dec
    import irq_stat_pkg::*;
#(
    parameter int OFFW = 8
) (
    input  logic [OFFW-1:0] off,
    output reg_sel_e        sel,
    output logic            hit
);
    // Map the offset onto one of the four registers, flag a miss.
    always_comb begin
        sel = SEL_RAW;
        hit = 1'b1;
        if (off == OFFW'(OFF_RAW))      sel = SEL_RAW;
        else if (off == OFFW'(OFF_REQ)) sel = SEL_REQ;
        else if (off == OFFW'(OFF_EN))  sel = SEL_EN;
        else if (off == OFFW'(OFF_DET)) sel = SEL_DET;
        else                            hit = 1'b0;
    end
endmodule

// File: rtl/irq_chan_regs.sv
// One channel's interrupt state: live view, sticky request with
// write-one-to-clear, enable mask, masked detect and level interrupt.
// Assumes at most one of wr_req / wr_en is high in a cycle.
module irq_chan_regs
    import irq_stat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_done,
    input  logic          ev_abort,
    input  logic          wr_req,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raw,
    output logic [DW-1:0] req,
    output logic [DW-1:0] en,
    output logic [DW-1:0] det,
    output logic          irq
);
    localparam logic [DW-1:0] IMPL_MASK = (DW'(1) << DONE_BIT) | (DW'(1) << ABORT_BIT);

    logic [DW-1:0] clr;
    logic [DW-1:0] req_q;
    logic [DW-1:0] en_q;

    // Place the live event inputs at their bit positions.
    always_comb begin
        raw            = '0;
        raw[DONE_BIT]  = ev_done;
        raw[ABORT_BIT] = ev_abort;
    end

    // Bits software asks to clear this cycle.
    always_comb clr = wr_req ? (wdata & IMPL_MASK) : '0;

    // Sticky request: clear first, then new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~clr) | raw;
    end

    // Enable mask keeps only implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata & IMPL_MASK;
    end

    // Masked detect and the channel's level interrupt.
    always_comb begin
        req = req_q;
        en  = en_q;
        det = req_q & en_q;
        irq = |det;
    end
endmodule

// File: rtl/irq_rd_mux.sv
// Selects the read data of the addressed channel and register.
// Assumes out-of-range channel indices and unmapped offsets read zero.
module irq_rd_mux
    import irq_stat_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int CHW = 2
) (
    input  logic [CHW-1:0]         chan,
    input  reg_sel_e               sel,
    input  logic                   hit,
    input  logic [NCH-1:0][DW-1:0] raw_vec,
    input  logic [NCH-1:0][DW-1:0] req_vec,
    input  logic [NCH-1:0][DW-1:0] en_vec,
    input  logic [NCH-1:0][DW-1:0] det_vec,
    output logic [DW-1:0]          rd_data
);
    // Pick one register of one channel, zero otherwise.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit && chan == CHW'(c)) begin
                case (sel)
                    SEL_RAW: rd_data = raw_vec[c];
                    SEL_REQ: rd_data = req_vec[c];
                    SEL_EN:  rd_data = en_vec[c];
                    default: rd_data = det_vec[c];
                endcase
            end
        end
    end
endmodule

// File: rtl/chan_irq_bank.sv
// Interrupt status bank for NCH DMA channels with one shared line.
// Assumes single-cycle or level event inputs and a same-cycle read path.
module chan_irq_bank
    import irq_stat_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 32,
    parameter int OFFW = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  evt_done,
    input  logic [NCH-1:0]  evt_abort,
    input  logic            bus_wr,
    input  logic [CHW-1:0]  bus_chan,
    input  logic [OFFW-1:0] bus_off,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   rd_data,
    output logic [NCH-1:0]  irq_chan,
    output logic            irq_shared
);
    reg_sel_e               sel;
    logic                   hit;
    logic [NCH-1:0][DW-1:0] raw_vec;
    logic [NCH-1:0][DW-1:0] req_vec;
    logic [NCH-1:0][DW-1:0] en_vec;
    logic [NCH-1:0][DW-1:0] det_vec;

    irq_addr_dec #(.OFFW(OFFW)) u_dec (
        .off (bus_off),
        .sel (sel),
        .hit (hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic wr_hit;
        // Write strobe reaches only the addressed channel.
        always_comb wr_hit = bus_wr && hit && (bus_chan == CHW'(c));

        irq_chan_regs #(.DW(DW)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_done  (evt_done[c]),
            .ev_abort (evt_abort[c]),
            .wr_req   (wr_hit && sel == SEL_REQ),
            .wr_en    (wr_hit && sel == SEL_EN),
            .wdata    (bus_wdata),
            .raw      (raw_vec[c]),
            .req      (req_vec[c]),
            .en       (en_vec[c]),
            .det      (det_vec[c]),
            .irq      (irq_chan[c])
        );
    end

    irq_rd_mux #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_mux (
        .chan    (bus_chan),
        .sel     (sel),
        .hit     (hit),
        .raw_vec (raw_vec),
        .req_vec (req_vec),
        .en_vec  (en_vec),
        .det_vec (det_vec),
        .rd_data (rd_data)
    );

    // Shared line: any channel asserting.
    always_comb irq_shared = |irq_chan;
endmodule

// File: rtl/irq_bank_chk.sv
// Property checker for chan_irq_bank, attached with bind below.
// Assumes the register map and bit positions of irq_stat_pkg.
module irq_bank_chk
    import irq_stat_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 32,
    parameter int OFFW = 8,
    parameter int CHW  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         evt_done,
    input logic [NCH-1:0]         evt_abort,
    input logic                   bus_wr,
    input logic [CHW-1:0]         bus_chan,
    input logic [OFFW-1:0]        bus_off,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          rd_data,
    input logic [NCH-1:0][DW-1:0] req_vec,
    input logic [NCH-1:0][DW-1:0] en_vec,
    input logic [NCH-1:0]         irq_chan,
    input logic                   irq_shared
);
    localparam logic [DW-1:0] IMPL = (DW'(1) << DONE_BIT) | (DW'(1) << ABORT_BIT);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_vec == '0 && en_vec == '0)); // R1

    AST_SHARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_chan == '0) |-> !irq_shared); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_p
        logic addr_c;
        always_comb addr_c = (bus_chan == CHW'(c));

        AST_RAW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_c && bus_off == OFFW'(OFF_RAW)) |->
            (rd_data[DONE_BIT] == evt_done[c] && rd_data[ABORT_BIT] == evt_abort[c])); // R2

        AST_ABORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            evt_abort[c] |=> req_vec[c][ABORT_BIT]); // R3

        AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            evt_done[c] |=> req_vec[c][DONE_BIT]); // R3

        AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && addr_c && bus_off == OFFW'(OFF_REQ) && bus_wdata[DONE_BIT] && !evt_done[c])
            |=> !req_vec[c][DONE_BIT]); // R4

        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && addr_c && bus_off == OFFW'(OFF_REQ) && bus_wdata[ABORT_BIT] && evt_abort[c])
            |=> req_vec[c][ABORT_BIT]); // R5

        AST_EN_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[c] & ~IMPL) == '0); // R6

        AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            ((req_vec[c] & en_vec[c]) == '0) |-> !irq_chan[c]); // R8

        AST_CHAN_TO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_chan[c] |-> irq_shared); // R8

        AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_done[c] && !evt_abort[c] && !(bus_wr && addr_c))
            |=> (req_vec[c] == $past(req_vec[c]) && en_vec[c] == $past(en_vec[c]))); // R9
    end
endmodule

bind chan_irq_bank irq_bank_chk #(
    .NCH(NCH), .DW(DW), .OFFW(OFFW), .CHW(CHW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_done   (evt_done),
    .evt_abort  (evt_abort),
    .bus_wr     (bus_wr),
    .bus_chan   (bus_chan),
    .bus_off    (bus_off),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .req_vec    (req_vec),
    .en_vec     (en_vec),
    .irq_chan   (irq_chan),
    .irq_shared (irq_shared)
);

// File: tb/test_chan_irq_bank.sv
// Bench for chan_irq_bank: directed scenarios plus a behavioural cycle
// model compared one time unit after every rising edge.
module test_chan_irq_bank;
    localparam int NCH = 4;
    localparam int CHW = 2;
    localparam logic [31:0] B_DONE  = 32'h0000_0002;
    localparam logic [31:0] B_ABORT = 32'h0000_2000;
    localparam logic [31:0] B_BOTH  = 32'h0000_2002;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] evt_done = '0;
    logic [NCH-1:0] evt_abort = '0;
    logic           bus_wr = 1'b0;
    logic [CHW-1:0] bus_chan = '0;
    logic [7:0]     bus_off = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] irq_chan;
    logic           irq_shared;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_req [NCH];
    logic [31:0] m_en  [NCH];

    chan_irq_bank #(.NCH(NCH)) i_chan_irq_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_done   (evt_done),
        .evt_abort  (evt_abort),
        .bus_wr     (bus_wr),
        .bus_chan   (bus_chan),
        .bus_off    (bus_off),
        .bus_wdata  (bus_wdata),
        .rd_data    (rd_data),
        .irq_chan   (irq_chan),
        .irq_shared (irq_shared)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] live(input int c);
        return (evt_abort[c] ? B_ABORT : 32'h0) | (evt_done[c] ? B_DONE : 32'h0);
    endfunction

    // Cycle model: update on the edge, compare one unit later.
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_req[c] = '0;
                m_en[c]  = '0;
            end else begin
                logic wsel;
                wsel = bus_wr && (int'(bus_chan) == c);
                if (wsel && bus_off == 8'h14)
                    m_req[c] = m_req[c] & ~(bus_wdata & B_BOTH);
                m_req[c] = m_req[c] | live(c);
                if (wsel && bus_off == 8'h18)
                    m_en[c] = bus_wdata & B_BOTH;
            end
        end
        #1;
        begin
            logic [NCH-1:0] e_irq;
            logic [31:0] e_rd;
            int ch;
            for (int c = 0; c < NCH; c++) e_irq[c] = |(m_req[c] & m_en[c]);
            chk("R8 irq_chan", {28'h0, irq_chan}, {28'h0, e_irq});
            chk("R8 irq_shared", {31'h0, irq_shared}, {31'h0, |e_irq});
            ch = int'(bus_chan);
            case (bus_off)
                8'h10: begin e_rd = live(ch);                chk("R2 model raw", rd_data, e_rd); end
                8'h14: begin e_rd = m_req[ch];               chk("R4 model req", rd_data, e_rd); end
                8'h18: begin e_rd = m_en[ch];                chk("R6 model en", rd_data, e_rd); end
                8'h1C: begin e_rd = m_req[ch] & m_en[ch];    chk("R7 model det", rd_data, e_rd); end
                default: begin e_rd = '0;                    chk("R7 model unmapped", rd_data, e_rd); end
            endcase
        end
    end

    task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_chan = CHW'(ch); bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [7:0] off, output logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_chan = CHW'(ch); bus_off = off;
        #1 v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared state after reset
        rd(0, 8'h14, v); chk("R1 req after reset", v, 32'h0);
        rd(3, 8'h18, v); chk("R1 en after reset", v, 32'h0);
        chk("R1 shared low", {31'h0, irq_shared}, 32'h0);

        // R3: masked abort still latches, no interrupt
        @(negedge clk); evt_abort[2] = 1'b1;
        @(negedge clk); evt_abort[2] = 1'b0;
        rd(2, 8'h14, v); chk("R3 masked abort latched", v, B_ABORT);
        chk("R8 masked no irq", {28'h0, irq_chan}, 32'h0);
        rd(2, 8'h1C, v); chk("R7 det zero while masked", v, 32'h0);

        // R6/R7/R8: enabling exposes the pending abort
        wr(2, 8'h18, 32'hFFFF_FFFF);
        rd(2, 8'h18, v); chk("R6 en implemented bits", v, B_BOTH);
        rd(2, 8'h1C, v); chk("R7 det", v, B_ABORT);
        chk("R8 chan2 irq", {28'h0, irq_chan}, 32'h4);
        chk("R8 shared high", {31'h0, irq_shared}, 32'h1);

        // R4: zero bits leave request alone, one bit clears
        wr(2, 8'h14, B_DONE);
        rd(2, 8'h14, v); chk("R4 zero has no effect", v, B_ABORT);
        wr(2, 8'h14, B_ABORT);
        rd(2, 8'h14, v); chk("R4 one clears", v, 32'h0);
        chk("R8 irq drops", {31'h0, irq_shared}, 32'h0);

        // R5: event and clear on the same edge
        @(negedge clk);
        evt_done[1] = 1'b1; bus_wr = 1'b1; bus_chan = 2'd1; bus_off = 8'h14; bus_wdata = B_BOTH;
        @(negedge clk);
        evt_done[1] = 1'b0; bus_wr = 1'b0;
        rd(1, 8'h14, v); chk("R5 event wins", v, B_DONE);

        // R9 and R7: writes stay in their channel; read-only offsets ignore writes
        @(negedge clk); evt_done[0] = 1'b1; evt_done[3] = 1'b1;
        @(negedge clk); evt_done = '0;
        wr(0, 8'h14, B_BOTH);
        wr(0, 8'h18, B_BOTH);
        rd(3, 8'h14, v); chk("R9 other channel req kept", v, B_DONE);
        rd(3, 8'h18, v); chk("R9 other channel en kept", v, 32'h0);
        rd(0, 8'h14, v); chk("R9 addressed channel cleared", v, 32'h0);
        wr(3, 8'h1C, 32'hFFFF_FFFF);
        wr(3, 8'h10, 32'hFFFF_FFFF);
        rd(3, 8'h14, v); chk("R7 ro write req kept", v, B_DONE);
        rd(3, 8'h18, v); chk("R7 ro write en kept", v, 32'h0);
        rd(3, 8'h24, v); chk("R7 unmapped reads zero", v, 32'h0);

        // R2: live view follows held inputs
        @(negedge clk); evt_done[0] = 1'b1;
        bus_chan = 2'd0; bus_off = 8'h10;
        #1 chk("R2 raw done", rd_data, B_DONE);
        @(negedge clk); evt_done[0] = 1'b0; evt_abort[0] = 1'b1;
        #1 chk("R2 raw abort", rd_data, B_ABORT);
        @(negedge clk); evt_abort[0] = 1'b0;

        // Random mix, checked by the cycle model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                evt_done[c]  = ($urandom % 8) == 0;
                evt_abort[c] = ($urandom % 12) == 0;
            end
            bus_wr    = ($urandom % 3) == 0;
            bus_chan  = CHW'($urandom);
            case ($urandom % 5)
                0: bus_off = 8'h10;
                1: bus_off = 8'h14;
                2: bus_off = 8'h18;
                3: bus_off = 8'h1C;
                default: bus_off = 8'h20;
            endcase
            bus_wdata = $urandom;
        end
        @(negedge clk); evt_done = '0; evt_abort = '0; bus_wr = 1'b0;
        @(negedge clk);
        finished = 1;
    end

    // Watchdog and summary.
    initial begin
        int n = 0;
        while (!finished && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule